// File: doc/BRIEF.md
# Sound-CPU Mailbox and Register Window

This block decodes the sixteen-byte register page of a small sound processor. It holds the mailbox that joins that processor to a host CPU. There are four mailbox ports, and each port carries two separate bytes. The host writes one byte and the sound CPU reads it. The sound CPU writes the other byte and the host reads it. Neither side ever sees its own writes. A control write from the sound side can zero the host-written bytes in pairs of ports. The same control write sets whether the boot ROM is mapped over the top 64 bytes of the address space.

The page also contains an indirect window onto a 128-entry DSP register file. One register selects the DSP index and the next one carries the data. A flag in the index register's top bit stops writes from passing through the window. Reads through the window always work. Address bytes that belong to plain RAM, and the boot area on writes, are flagged to the RAM through `snd_ram_wr`.

Sound-side reads are registered. `snd_claim` and `snd_rdata` are valid in the cycle after the clock edge that samples `snd_rd`. When `snd_claim` is low, the read belongs to RAM or to a neighbouring block.

Top module: `sound_io_regs`

## Requirements
- R1: After reset, all eight mailbox bytes read $00 from both sides, and a read of $FFC0 is claimed and returns boot ROM data.
- R2: A host write to port p (p = 0..3) is returned by a sound read of $F4+p. A sound write to $F4+p is returned by a host read of port p. A write by either side leaves unchanged the byte that side reads.
- R3: A sound write to $F1 with bit 4 set zeroes the host-written bytes of ports 0 and 1. Bit 5 does the same for ports 2 and 3. A port whose bit is clear keeps its value.
- R4: A clear acts only in the cycle of the control write. Later host writes land normally, and the sound-written bytes are never touched by a clear.
- R5: If a host write and a clearing control write hit the same port in one cycle, the port reads $00 afterwards.
- R6: If a host write and a sound read hit the same port in one cycle, the read returns the value held before that write.
- R7: A sound write to $F2 stores bits 6:0 as the DSP index, which is driven on `dsp_addr`, and stores bit 7 as a write-block flag. A read of $F2 returns the index with bit 7 as 0.
- R8: A sound write to $F3 pulses `dsp_wr` with the written byte on `dsp_wdata` only when the write-block flag is 0. When the flag is 1, the DSP file is left unchanged.
- R9: A read of $F3 returns `dsp_rdata` for the current index, whatever the state of the write-block flag.
- R10: While bit 7 of the last $F1 write is 1 (reset value $B0), reads of $FFC0..$FFFF are claimed and return the ROM byte (29*k + 90) mod 256 for offset k. While that bit is 0, such reads are not claimed.
- R11: Writes to $FFC0..$FFFF always raise `snd_ram_wr`.
- R12: Reads of $F0 and $F1 are claimed and return $00. $F8 and $F9 act as RAM: reads are not claimed and writes raise `snd_ram_wr`. $FA..$FF are neither claimed nor written to RAM. Port writes do not raise `snd_ram_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_addr | input | 16 | Sound CPU address |
| snd_wdata | input | 8 | Sound CPU write data |
| snd_wr | input | 1 | Sound CPU write strobe |
| snd_rd | input | 1 | Sound CPU read strobe |
| snd_rdata | output | 8 | Registered read data, valid one cycle after the read |
| snd_claim | output | 1 | This block supplies the read data (registered) |
| snd_ram_wr | output | 1 | The current write goes to RAM |
| host_sel | input | 2 | Host port number |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Sound-written byte of the selected port |
| dsp_addr | output | 7 | Selected DSP register index |
| dsp_wr | output | 1 | DSP register write strobe |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register contents at `dsp_addr` |

## Verification
The mailbox is exercised with a distinct byte in every port. This exposes swapped port decoding and cross-direction leaks. Reading a port back after the sound CPU has written the same port shows that the two directions are kept apart. The two clear bits are tried one at a time, which separates the two port pairs and shows that the sound-written bytes survive a clear. Collision patterns cover a host write against a clear and a host write against a read of the same port. The DSP window is driven with the write-block flag both clear and set, and the boot area is read and written with the ROM both mapped and unmapped.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
   // offsets inside the sixteen-byte register page
   localparam int OFS_TEST  = 0;
   localparam int OFS_CTRL  = 1;
   localparam int OFS_IDX   = 2;
   localparam int OFS_DATA  = 3;
   localparam int OFS_PORT0 = 4;
   localparam int OFS_RAM0  = 8;

   typedef struct packed {
      logic test;
      logic ctrl;
      logic idx;
      logic data;
      logic port;
      logic ram;
      logic boot;
   } sio_hit_t;
endpackage

// File: rtl/sio_decode.sv
`timescale 1ns/1ps
module sio_decode import sio_pkg::*; #(
   parameter int AW       = 16,
   parameter int ROM_AW   = 6,
   parameter int NPORTS   = 4,
   parameter int REG_BASE = 'hF0,
   localparam int PW      = $clog2(NPORTS)
) (
   input  logic [AW-1:0] addr,
   output sio_hit_t      hit,
   output logic [PW-1:0] port_sel
);
   localparam logic [AW-1:0] BASE = AW'(REG_BASE);

   logic       in_page;
   logic [3:0] ofs;

   assign in_page = (addr[AW-1:4] == BASE[AW-1:4]);
   assign ofs     = addr[3:0];

   always_comb begin
      hit      = '0;
      hit.test = in_page && (int'(ofs) == OFS_TEST);
      hit.ctrl = in_page && (int'(ofs) == OFS_CTRL);
      hit.idx  = in_page && (int'(ofs) == OFS_IDX);
      hit.data = in_page && (int'(ofs) == OFS_DATA);
      hit.port = in_page && (int'(ofs) >= OFS_PORT0) && (int'(ofs) < OFS_PORT0 + NPORTS);
      hit.ram  = !in_page || (int'(ofs) == OFS_RAM0) || (int'(ofs) == OFS_RAM0 + 1);
      hit.boot = &addr[AW-1:ROM_AW];
   end

   assign port_sel = PW'(int'(ofs) - OFS_PORT0);
endmodule

// File: rtl/sio_mailbox.sv
`timescale 1ns/1ps
module sio_mailbox #(
   parameter int NPORTS  = 4,
   parameter int DW      = 8,
   parameter int GROUP   = 2,
   localparam int PW     = $clog2(NPORTS),
   localparam int NGRP   = NPORTS / GROUP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_wr,
   input  logic [PW-1:0]   host_sel,
   input  logic [DW-1:0]   host_wdata,
   output logic [DW-1:0]   host_rdata,
   input  logic            snd_wr,
   input  logic [PW-1:0]   snd_sel,
   input  logic [DW-1:0]   snd_wdata,
   output logic [DW-1:0]   h2s_rd,
   input  logic [NGRP-1:0] clr_grp
);
   logic [NPORTS-1:0][DW-1:0] h2s;   // host writes, sound reads
   logic [NPORTS-1:0][DW-1:0] s2h;   // sound writes, host reads

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h2s <= '0;
         s2h <= '0;
      end else begin
         for (int p = 0; p < NPORTS; p++) begin
            if (clr_grp[p / GROUP])
               h2s[p] <= '0;
            else if (host_wr && host_sel == PW'(p))
               h2s[p] <= host_wdata;
            if (snd_wr && snd_sel == PW'(p))
               s2h[p] <= snd_wdata;
         end
      end
   end

   assign h2s_rd     = h2s[snd_sel];
   assign host_rdata = s2h[host_sel];

   for (genvar p = 0; p < NPORTS; p++) begin : g_chk
      // R4
      s2h_clear_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|clr_grp && !(snd_wr && snd_sel == PW'(p))) |=> $stable(s2h[p]));
      // R5
      clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr_grp[p / GROUP] |=> (h2s[p] == '0));
      // R2
      own_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((!host_wr || host_sel != PW'(p)) && !clr_grp[p / GROUP]) |=> $stable(h2s[p]));
   end
endmodule

// File: rtl/sio_dsp_window.sv
`timescale 1ns/1ps
module sio_dsp_window #(
   parameter int DW     = 8,
   parameter int DSP_AW = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic              data_wr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     idx_rd,
   output logic [DSP_AW-1:0] dsp_addr,
   output logic              dsp_wr,
   output logic [DW-1:0]     dsp_wdata
);
   logic [DSP_AW-1:0] idx_q;
   logic              lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         lock_q <= 1'b0;
      end else if (idx_wr) begin
         idx_q  <= wdata[DSP_AW-1:0];
         lock_q <= wdata[DW-1];
      end
   end

   assign idx_rd    = DW'(idx_q);
   assign dsp_addr  = idx_q;
   assign dsp_wr    = data_wr && !lock_q;
   assign dsp_wdata = wdata;

   // R8
   lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && $past(idx_wr && wdata[DW-1])) |-> !dsp_wr);
   // R7
   idx_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(idx_wr) |-> (dsp_addr == $past(wdata[DSP_AW-1:0])));
endmodule

// File: rtl/sio_boot_rom.sv
`timescale 1ns/1ps
module sio_boot_rom #(
   parameter int DW     = 8,
   parameter int ROM_AW = 6,
   parameter int MUL    = 29,
   parameter int SEED   = 90,
   localparam int DEPTH = 1 << ROM_AW
) (
   input  logic [ROM_AW-1:0] idx,
   output logic [DW-1:0]     data
);
   if (DEPTH > 4096) begin : g_bad_depth
      $error("boot ROM depth too large");
   end

   logic [DW-1:0] tbl [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
      assign tbl[k] = DW'(k * MUL + SEED);
   end

   assign data = tbl[idx];
endmodule

// File: rtl/sound_io_regs.sv
`timescale 1ns/1ps
module sound_io_regs import sio_pkg::*; #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int NPORTS    = 4,
   parameter int CLR_GROUP = 2,
   parameter int CLR_LSB   = 4,
   parameter int BOOT_BIT  = 7,
   parameter int DSP_AW    = 7,
   parameter int ROM_AW    = 6,
   parameter int REG_BASE  = 'hF0,
   localparam int PW       = $clog2(NPORTS),
   localparam int NGRP     = NPORTS / CLR_GROUP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     snd_addr,
   input  logic [DW-1:0]     snd_wdata,
   input  logic              snd_wr,
   input  logic              snd_rd,
   output logic [DW-1:0]     snd_rdata,
   output logic              snd_claim,
   output logic              snd_ram_wr,
   input  logic [PW-1:0]     host_sel,
   input  logic              host_wr,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata,
   output logic [DSP_AW-1:0] dsp_addr,
   output logic              dsp_wr,
   output logic [DW-1:0]     dsp_wdata,
   input  logic [DW-1:0]     dsp_rdata
);
   localparam logic [AW-1:0] A_TEST = AW'(REG_BASE + OFS_TEST);
   localparam logic [AW-1:0] A_CTRL = AW'(REG_BASE + OFS_CTRL);
   localparam logic [AW-1:0] A_IDX  = AW'(REG_BASE + OFS_IDX);

   // elaboration-time parameter checks
   if (NPORTS < 2 || (1 << PW) != NPORTS) begin : g_bad_ports
      $error("NPORTS must be a power of two, at least 2");
   end
   if (NPORTS % CLR_GROUP != 0) begin : g_bad_group
      $error("NPORTS must be a multiple of CLR_GROUP");
   end
   if (CLR_LSB + NGRP > DW || BOOT_BIT >= DW) begin : g_bad_ctrl
      $error("control fields exceed data width");
   end
   if (DW < DSP_AW + 1) begin : g_bad_dsp
      $error("data width must hold index plus lock flag");
   end
   if (OFS_PORT0 + NPORTS > OFS_RAM0) begin : g_bad_map
      $error("ports overlap RAM bytes in the page");
   end

   sio_hit_t      hit;
   logic [PW-1:0] port_sel;

   sio_decode #(.AW(AW), .ROM_AW(ROM_AW), .NPORTS(NPORTS), .REG_BASE(REG_BASE)) u_dec (
      .addr     (snd_addr),
      .hit      (hit),
      .port_sel (port_sel)
   );

   // control register: only the boot-map bit is stored, clears are pulses
   logic            boot_en_q;
   logic            ctrl_wr;
   logic [NGRP-1:0] clr_grp;

   assign ctrl_wr = snd_wr && hit.ctrl;
   assign clr_grp = ctrl_wr ? snd_wdata[CLR_LSB +: NGRP] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         boot_en_q <= 1'b1;
      else if (ctrl_wr)
         boot_en_q <= snd_wdata[BOOT_BIT];
   end

   logic [DW-1:0] h2s_rd;

   sio_mailbox #(.NPORTS(NPORTS), .DW(DW), .GROUP(CLR_GROUP)) u_mbox (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .snd_wr     (snd_wr && hit.port),
      .snd_sel    (port_sel),
      .snd_wdata  (snd_wdata),
      .h2s_rd     (h2s_rd),
      .clr_grp    (clr_grp)
   );

   logic [DW-1:0] idx_rd;

   sio_dsp_window #(.DW(DW), .DSP_AW(DSP_AW)) u_dsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (snd_wr && hit.idx),
      .data_wr   (snd_wr && hit.data),
      .wdata     (snd_wdata),
      .idx_rd    (idx_rd),
      .dsp_addr  (dsp_addr),
      .dsp_wr    (dsp_wr),
      .dsp_wdata (dsp_wdata)
   );

   logic [DW-1:0] rom_byte;

   sio_boot_rom #(.DW(DW), .ROM_AW(ROM_AW)) u_rom (
      .idx  (snd_addr[ROM_AW-1:0]),
      .data (rom_byte)
   );

   // read source selection
   logic [DW-1:0] rd_val;
   logic          rd_claim;

   always_comb begin
      rd_val   = '0;
      rd_claim = 1'b0;
      if (hit.test || hit.ctrl) begin
         rd_claim = 1'b1;
      end else if (hit.idx) begin
         rd_claim = 1'b1;
         rd_val   = idx_rd;
      end else if (hit.data) begin
         rd_claim = 1'b1;
         rd_val   = dsp_rdata;
      end else if (hit.port) begin
         rd_claim = 1'b1;
         rd_val   = h2s_rd;
      end else if (hit.boot && boot_en_q) begin
         rd_claim = 1'b1;
         rd_val   = rom_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snd_rdata <= '0;
         snd_claim <= 1'b0;
      end else begin
         snd_rdata <= snd_rd ? rd_val : '0;
         snd_claim <= snd_rd && rd_claim;
      end
   end

   assign snd_ram_wr = snd_wr && hit.ram;

   // R12
   wo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(snd_rd && (snd_addr == A_TEST || snd_addr == A_CTRL)) |-> (snd_rdata == '0 && snd_claim));
   // R7
   idx_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(snd_rd && snd_addr == A_IDX) |-> !snd_rdata[DW-1]);
   // R11
   boot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_wr && (&snd_addr[AW-1:ROM_AW])) |-> snd_ram_wr);
   // R10
   boot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(snd_rd && (&snd_addr[AW-1:ROM_AW]) && !boot_en_q) |-> !snd_claim);
endmodule

// File: tb/tb_sound_io_regs.sv
`timescale 1ns/1ps
module tb_sound_io_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] snd_addr = '0;
   logic [7:0]  snd_wdata = '0;
   logic        snd_wr = 1'b0;
   logic        snd_rd = 1'b0;
   logic [7:0]  snd_rdata;
   logic        snd_claim;
   logic        snd_ram_wr;
   logic [1:0]  host_sel = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [6:0]  dsp_addr;
   logic        dsp_wr;
   logic [7:0]  dsp_wdata;
   logic [7:0]  dsp_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sound_io_regs dut (
      .clk(clk), .rst_n(rst_n), .snd_addr(snd_addr), .snd_wdata(snd_wdata),
      .snd_wr(snd_wr), .snd_rd(snd_rd), .snd_rdata(snd_rdata), .snd_claim(snd_claim),
      .snd_ram_wr(snd_ram_wr), .host_sel(host_sel), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .dsp_addr(dsp_addr),
      .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata)
   );

   // bench model of the DSP register file
   logic [7:0] dmem [128];
   int         dsp_wr_cnt = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 128; k++) dmem[k] <= 8'(k) ^ 8'h3C;
      end else if (dsp_wr) begin
         dmem[dsp_addr] <= dsp_wdata;
         dsp_wr_cnt <= dsp_wr_cnt + 1;
      end
   end
   assign dsp_rdata = dmem[dsp_addr];

   function automatic logic [7:0] rom_exp(int k);
      return 8'((29 * k + 90) % 256);
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic snd_write(logic [15:0] a, logic [7:0] d, output logic ram);
      @(negedge clk);
      snd_addr = a; snd_wdata = d; snd_wr = 1'b1;
      #1 ram = snd_ram_wr;
      @(negedge clk);
      snd_wr = 1'b0;
   endtask

   task automatic snd_read(logic [15:0] a, output logic [7:0] d, output logic cl);
      @(negedge clk);
      snd_addr = a; snd_rd = 1'b1;
      @(negedge clk);
      snd_rd = 1'b0;
      d = snd_rdata; cl = snd_claim;
   endtask

   task automatic host_write(logic [1:0] p, logic [7:0] d);
      @(negedge clk);
      host_sel = p; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(logic [1:0] p, output logic [7:0] d);
      @(negedge clk);
      host_sel = p;
      #1 d = host_rdata;
   endtask

   // vector: op[38:37] req[36:33] addr[32:17] data[16:9] exp[8:1] claim[0]
   // op 0 sound write, 1 sound read check, 2 host write, 3 host read check
   localparam int NV = 26;
   localparam logic [38:0] VEC [NV] = '{
      {2'd2, 4'd2,  16'h0000, 8'hA1, 8'h00, 1'b0},  // R2 host fills ports
      {2'd2, 4'd2,  16'h0001, 8'hB2, 8'h00, 1'b0},
      {2'd2, 4'd2,  16'h0002, 8'hC3, 8'h00, 1'b0},
      {2'd2, 4'd2,  16'h0003, 8'hD4, 8'h00, 1'b0},
      {2'd1, 4'd2,  16'h00F4, 8'h00, 8'hA1, 1'b1},  // R2
      {2'd1, 4'd2,  16'h00F7, 8'h00, 8'hD4, 1'b1},
      {2'd0, 4'd2,  16'h00F5, 8'h5E, 8'h00, 1'b0},
      {2'd3, 4'd2,  16'h0001, 8'h00, 8'h5E, 1'b0},  // R2 host sees sound byte
      {2'd1, 4'd2,  16'h00F5, 8'h00, 8'hB2, 1'b1},  // R2 own write not seen
      {2'd0, 4'd3,  16'h00F1, 8'h90, 8'h00, 1'b0},  // R3 clear ports 0,1
      {2'd1, 4'd3,  16'h00F4, 8'h00, 8'h00, 1'b1},
      {2'd1, 4'd3,  16'h00F5, 8'h00, 8'h00, 1'b1},
      {2'd1, 4'd3,  16'h00F6, 8'h00, 8'hC3, 1'b1},  // R3 other pair kept
      {2'd3, 4'd4,  16'h0001, 8'h00, 8'h5E, 1'b0},  // R4 sound byte survives
      {2'd2, 4'd4,  16'h0000, 8'h77, 8'h00, 1'b0},  // R4 later write lands
      {2'd1, 4'd4,  16'h00F4, 8'h00, 8'h77, 1'b1},
      {2'd0, 4'd3,  16'h00F1, 8'hA0, 8'h00, 1'b0},  // R3 clear ports 2,3
      {2'd1, 4'd3,  16'h00F7, 8'h00, 8'h00, 1'b1},
      {2'd1, 4'd3,  16'h00F4, 8'h00, 8'h77, 1'b1},
      {2'd0, 4'd7,  16'h00F2, 8'h85, 8'h00, 1'b0},  // R7
      {2'd1, 4'd7,  16'h00F2, 8'h00, 8'h05, 1'b1},
      {2'd1, 4'd12, 16'h00F1, 8'h00, 8'h00, 1'b1},  // R12
      {2'd1, 4'd12, 16'h00F0, 8'h00, 8'h00, 1'b1},
      {2'd1, 4'd12, 16'h00F8, 8'h00, 8'h00, 1'b0},
      {2'd1, 4'd10, 16'hFFC0, 8'h00, 8'h5A, 1'b1},  // R10
      {2'd1, 4'd10, 16'hFFFF, 8'h00, 8'h7D, 1'b1}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      logic       cl;
      logic       ram;
      int         cnt0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int p = 0; p < 4; p++) begin
         snd_read(16'h00F4 + 16'(p), d, cl);
         check("R1", "port read after reset", d, 0);
         host_read(2'(p), d);
         check("R1", "host read after reset", d, 0);
      end
      snd_read(16'hFFC0, d, cl);
      check("R1", "boot mapped after reset", {cl, d}, {1'b1, rom_exp(0)});

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [38:0] v;
         string tg;
         v  = VEC[i];
         tg = $sformatf("R%0d", v[36:33]);
         case (v[38:37])
            2'd0: snd_write(v[32:17], v[16:9], ram);
            2'd1: begin
               snd_read(v[32:17], d, cl);
               check(tg, $sformatf("vec %0d data", i), d, v[8:1]);
               check(tg, $sformatf("vec %0d claim", i), cl, v[0]);
            end
            2'd2: host_write(v[18:17], v[16:9]);
            default: begin
               host_read(v[18:17], d);
               check(tg, $sformatf("vec %0d host data", i), d, v[8:1]);
            end
         endcase
      end

      // R8 unlocked write through the window
      snd_write(16'h00F2, 8'h12, ram);
      check("R7", "dsp_addr follows index", dsp_addr, 8'h12);
      cnt0 = dsp_wr_cnt;
      snd_write(16'h00F3, 8'h99, ram);
      check("R8", "dsp write count", dsp_wr_cnt, cnt0 + 1);
      check("R8", "dsp entry written", dmem[7'h12], 8'h99);
      // R8 locked write suppressed
      snd_write(16'h00F2, 8'h92, ram);
      cnt0 = dsp_wr_cnt;
      snd_write(16'h00F3, 8'h44, ram);
      check("R8", "locked dsp write count", dsp_wr_cnt, cnt0);
      check("R8", "locked dsp entry kept", dmem[7'h12], 8'h99);
      // R9 read works while locked
      snd_read(16'h00F3, d, cl);
      check("R9", "window read while locked", {cl, d}, {1'b1, 8'h99});
      snd_read(16'h00F2, d, cl);
      check("R7", "index readback drops flag", d, 8'h12);
      snd_write(16'h00F2, 8'h05, ram);
      snd_read(16'h00F3, d, cl);
      check("R9", "window read other entry", d, 8'h05 ^ 8'h3C);

      // R11 boot-area writes go to RAM with ROM mapped
      snd_write(16'hFFC5, 8'h33, ram);
      check("R11", "boot write to RAM (mapped)", ram, 1);
      // R12 RAM, port and timer-range write routing
      snd_write(16'h00F9, 8'h01, ram);
      check("R12", "F9 write to RAM", ram, 1);
      snd_write(16'h00F6, 8'h01, ram);
      check("R12", "port write not to RAM", ram, 0);
      snd_write(16'h00FB, 8'h01, ram);
      check("R12", "FB write not to RAM", ram, 0);
      snd_read(16'h00FD, d, cl);
      check("R12", "FD read not claimed", cl, 0);

      // R10 unmap the ROM
      snd_write(16'h00F1, 8'h00, ram);
      snd_read(16'hFFC0, d, cl);
      check("R10", "unmapped boot read claim", cl, 0);
      snd_write(16'hFFE0, 8'h33, ram);
      check("R11", "boot write to RAM (unmapped)", ram, 1);
      snd_write(16'h00F1, 8'h80, ram);
      snd_read(16'hFFE1, d, cl);
      check("R10", "remapped ROM byte", {cl, d}, {1'b1, rom_exp(33)});

      // R5 host write and clear on the same port in one cycle
      @(negedge clk);
      snd_addr = 16'h00F1; snd_wdata = 8'h90; snd_wr = 1'b1;
      host_sel = 2'd0; host_wdata = 8'hEE; host_wr = 1'b1;
      @(negedge clk);
      snd_wr = 1'b0; host_wr = 1'b0;
      snd_read(16'h00F4, d, cl);
      check("R5", "clear beats host write", d, 0);

      // R6 host write and sound read of one port in one cycle
      host_write(2'd2, 8'h11);
      @(negedge clk);
      host_sel = 2'd2; host_wdata = 8'h22; host_wr = 1'b1;
      snd_addr = 16'h00F6; snd_rd = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; snd_rd = 1'b0;
      check("R6", "collision read gets old value", snd_rdata, 8'h11);
      snd_read(16'h00F6, d, cl);
      check("R6", "next read gets new value", d, 8'h22);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule